// File: doc/BRIEF.md
# Pipeline Converter Digital Error Corrector

This block turns the raw one-bit decisions of a fourteen-stage, one-bit-per-stage pipeline converter, plus the bit of its final comparator, into a corrected 12-bit output code. Three of the fourteen stages have unity gain and add redundancy. Each of them resolves a bit at the same binary weight as the gain-of-two stage that follows it. If a comparator ahead of such a stage makes a small wrong decision, the error is absorbed when the two overlapping bits are added.

The stages resolve one after another on alternating clock phases, so the bits of one analog sample reach the block spread over several clock cycles. A per-bit deskew chain holds back the early bits until the whole sample is present. The aligned 15-bit word is registered. A column adder then counts the bits that share each weight and ripples the carries from the least significant column toward the most significant. An output register clamps any 13-bit overflow to full scale. A valid strobe marks each sample at its first-stage decision, and a matching output strobe marks each corrected code.

Top module: `adc_dec_corrector`

## Requirements
- R1: Raw input bit k is the decision of stage k in pipeline order: bit 0 is the first stage and bit 14 is the final comparator. Stages 2, 6 and 10 are the unity-gain stages. The output weight exponent of bit k is 11 for k=0, 10 for k=1, 9 for k=2..3, 8 for k=4, 7 for k=5, 6 for k=6..7, 5 for k=8, 4 for k=9, 3 for k=10..11, 2 for k=12, 1 for k=13 and 0 for k=14.
- R2: The bit of each unity-gain stage is added at the same weight as the bit that follows it, so two set bits in one column produce a carry into the next column.
- R3: The code is the binary sum of all weighted bits, with carries rippling from weight 0 up to weight 11.
- R4: A sum above 4095 is output as 4095.
- R5: With the default half-period stagger, bit k of a sample is presented on the input floor(k/2) clock cycles after the cycle in which the sample's valid strobe is presented. The block combines only bits that belong to the same sample.
- R6: A valid strobe sampled at clock edge t produces a one-cycle result strobe and the corresponding code after edge t+8.
- R7: Samples may start on every clock cycle, and their results come out on consecutive cycles in the same order.
- R8: While no result is produced, the result strobe is low and the code keeps its last value.
- R9: While reset is asserted, and on the first cycle after it is released, the result strobe is 0 and the code is 0.
- R10: With decisions from an ideal pipeline, an input at fraction x of full scale, with 0 <= x < 1, gives code floor(4096x). Assume the comparator of stage 1, 5 or 9 decides 0 for residues that lie less than 1/64 of full scale above its mid-scale threshold. The code is still floor(4096x).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_vld | input | 1 | Marks the cycle that carries a new sample's first-stage decision |
| raw_bits | input | 15 | Stage decisions, bit k from stage k, staggered in time |
| code_vld | output | 1 | One-cycle strobe marking a corrected code |
| code | output | 12 | Corrected, saturated output code |

## Verification
The bench targets three areas. The first is the overlapping columns, where a corrector that gave a unity-gain bit its own weight would shift codes by hundreds of LSBs. The second is long carry ripples, where a broken chain returns codes that are off by a power of two. The third is a full-scale input, which yields 4096 and must clamp rather than wrap to 0. It also drives samples back to back with complementary bit patterns, so a lane with the wrong delay mixes bits of neighbouring samples and the codes come out visibly wrong. Ideal and comparator-offset pipeline decisions near the major transitions show whether the redundancy really absorbs a decision error or leaves the code one step off.

// File: rtl/adc_dec_pkg.sv
package adc_dec_pkg;

   // Number of unity-gain stages located below raw index k.
   function automatic int redun_below(input logic [63:0] mask, input int k);
      int n;
      n = 0;
      for (int i = 0; i < 64; i++) begin
         if (i < k && mask[i]) n++;
      end
      return n;
   endfunction

   // Output weight exponent of raw bit k. A unity-gain bit lands on the
   // same column as its successor because it is not counted below itself.
   function automatic int weight_exp(input logic [63:0] mask, input int out_w, input int k);
      return out_w - 1 - (k - redun_below(mask, k));
   endfunction

   // Largest sum the adder can produce when every raw bit is set.
   function automatic longint max_sum(input logic [63:0] mask, input int n_raw, input int out_w);
      longint s;
      int e;
      s = 0;
      for (int k = 0; k < 64; k++) begin
         if (k < n_raw) begin
            e = weight_exp(mask, out_w, k);
            if (e >= 0) s = s + (longint'(1) << e);
         end
      end
      return s;
   endfunction

endpackage

// File: rtl/adc_dec_shift.sv
module adc_dec_shift #(
   parameter int LEN = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [LEN-1:0] stg;

   if (LEN < 1) begin : g_bad_len
      $error("adc_dec_shift: LEN must be at least 1");
   end

   if (LEN == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg <= '0;
         else        stg <= d;
      end
   end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg <= '0;
         else        stg <= {stg[LEN-2:0], d};
      end
   end

   assign q = stg[LEN-1];
endmodule

// File: rtl/adc_dec_deskew.sv
module adc_dec_deskew #(
   parameter int NUM_RAW      = 15,
   parameter bit HALF_STAGGER = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_vld,
   input  logic [NUM_RAW-1:0] in_raw,
   output logic               al_vld,
   output logic [NUM_RAW-1:0] al_raw
);
   // Arrival lag of the last lane relative to the first.
   localparam int MAX_LAG = HALF_STAGGER ? ((NUM_RAW - 1) / 2) : (NUM_RAW - 1);

   for (genvar k = 0; k < NUM_RAW; k++) begin : g_lane
      localparam int LAG = HALF_STAGGER ? (k / 2) : k;
      localparam int LEN = MAX_LAG - LAG + 1;
      adc_dec_shift #(.LEN(LEN)) u_lane (
         .clk  (clk),
         .rst_n(rst_n),
         .d    (in_raw[k]),
         .q    (al_raw[k])
      );
   end

   // The strobe travels with lane 0, which has the longest chain.
   adc_dec_shift #(.LEN(MAX_LAG + 1)) u_vld (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (in_vld),
      .q    (al_vld)
   );
endmodule

// File: rtl/adc_dec_ripple.sv
module adc_dec_ripple #(
   parameter int                 NUM_RAW    = 15,
   parameter int                 OUT_W      = 12,
   parameter logic [NUM_RAW-1:0] REDUN_MASK = 15'h0444
) (
   input  logic [NUM_RAW-1:0] raw_i,
   output logic [OUT_W:0]     sum_o
);
   localparam int CNT_W = 2;

   logic [CNT_W-1:0] col_cnt [OUT_W];

   // Population count of each weight column (at most two bits share one).
   always_comb begin
      for (int c = 0; c < OUT_W; c++) begin
         col_cnt[c] = '0;
         for (int k = 0; k < NUM_RAW; k++) begin
            if (adc_dec_pkg::weight_exp(64'(REDUN_MASK), OUT_W, k) == c)
               col_cnt[c] = col_cnt[c] + {{(CNT_W-1){1'b0}}, raw_i[k]};
         end
      end
   end

   // Carry ripple from the lowest column upward.
   logic [CNT_W-1:0] tot;
   logic             cy;
   always_comb begin
      cy  = 1'b0;
      tot = '0;
      for (int c = 0; c < OUT_W; c++) begin
         tot      = col_cnt[c] + {{(CNT_W-1){1'b0}}, cy};
         sum_o[c] = tot[0];
         cy       = tot[1];
      end
      sum_o[OUT_W] = cy;
   end
endmodule

// File: rtl/adc_dec_outreg.sv
module adc_dec_outreg #(
   parameter int OUT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sum_vld,
   input  logic [OUT_W:0]   sum_i,
   output logic             code_vld,
   output logic [OUT_W-1:0] code
);
   localparam logic [OUT_W-1:0] FULL = '1;

   logic [OUT_W-1:0] next_code;

   always_comb next_code = sum_i[OUT_W] ? FULL : sum_i[OUT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_vld <= 1'b0;
         code     <= '0;
      end else begin
         code_vld <= sum_vld;
         if (sum_vld) code <= next_code;
      end
   end

   AST_CLAMP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (sum_vld && sum_i[OUT_W]) |=> (code == FULL));                      // R4
   AST_PASS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (sum_vld && !sum_i[OUT_W]) |=> (code == $past(sum_i[OUT_W-1:0])));  // R3
   AST_HOLD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      !sum_vld |=> ($stable(code) && !code_vld));                          // R8
   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (!code_vld && code == '0));                        // R9
endmodule

// File: rtl/adc_dec_corrector.sv
module adc_dec_corrector #(
   parameter int                      NUM_STAGES   = 14,
   parameter int                      OUT_W        = 12,
   parameter logic [NUM_STAGES:0]     REDUN_MASK   = 15'h0444,
   parameter bit                      HALF_STAGGER = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  raw_vld,
   input  logic [NUM_STAGES:0]   raw_bits,
   output logic                  code_vld,
   output logic [OUT_W-1:0]      code
);
   localparam int              NUM_RAW = NUM_STAGES + 1;
   localparam int              SUM_W   = OUT_W + 1;
   localparam logic [SUM_W-1:0] MAX_SUM =
      SUM_W'(adc_dec_pkg::max_sum(64'(REDUN_MASK), NUM_RAW, OUT_W));

   if (NUM_RAW > 63 || OUT_W > 61) begin : g_bad_size
      $error("adc_dec_corrector: raw width or output width too large");
   end
   if (OUT_W != NUM_RAW - $countones(REDUN_MASK)) begin : g_bad_width
      $error("adc_dec_corrector: OUT_W must equal raw bits minus redundant stages");
   end
   if (REDUN_MASK[NUM_RAW-1]) begin : g_bad_last
      $error("adc_dec_corrector: the final comparator cannot be redundant");
   end
   if ((REDUN_MASK & (REDUN_MASK >> 1)) != '0) begin : g_bad_adjacent
      $error("adc_dec_corrector: redundant stages must not be adjacent");
   end

   logic               al_vld;
   logic [NUM_RAW-1:0] al_raw;
   logic [SUM_W-1:0]   sum;

   adc_dec_deskew #(
      .NUM_RAW     (NUM_RAW),
      .HALF_STAGGER(HALF_STAGGER)
   ) u_deskew (
      .clk   (clk),
      .rst_n (rst_n),
      .in_vld(raw_vld),
      .in_raw(raw_bits),
      .al_vld(al_vld),
      .al_raw(al_raw)
   );

   adc_dec_ripple #(
      .NUM_RAW   (NUM_RAW),
      .OUT_W     (OUT_W),
      .REDUN_MASK(REDUN_MASK)
   ) u_ripple (
      .raw_i(al_raw),
      .sum_o(sum)
   );

   adc_dec_outreg #(
      .OUT_W(OUT_W)
   ) u_outreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .sum_vld (al_vld),
      .sum_i   (sum),
      .code_vld(code_vld),
      .code    (code)
   );

   AST_SUM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      al_vld |-> (sum <= MAX_SUM));                                        // R2
endmodule

// File: tb/adc_dec_corrector_bench.sv
`timescale 1ns/1ps
module adc_dec_corrector_bench;
   localparam int     NR   = 15;
   localparam int     OW   = 12;
   localparam longint ONE  = 64'd1 << 20;
   localparam longint HALF = ONE / 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          raw_vld = 1'b0;
   logic [NR-1:0] raw_bits = '0;
   logic          code_vld;
   logic [OW-1:0] code;

   adc_dec_corrector u_adc_dec_corrector (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_vld (raw_vld),
      .raw_bits(raw_bits),
      .code_vld(code_vld),
      .code    (code)
   );

   always #2.5 clk = ~clk;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   int last_code = 0;
   logic [NR-1:0] sbits [32];
   logic          svld  [32];

   typedef struct {int due; int val; string tag;} exp_t;
   exp_t expq[$];

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
      end
   endtask

   // Weight exponents written out from R1.
   function automatic int ref_exp(input int k);
      return 11 - k + int'(k > 2) + int'(k > 6) + int'(k > 10);
   endfunction

   function automatic int ref_code(input logic [NR-1:0] raw);
      int s;
      s = 0;
      for (int k = 0; k < NR; k++) if (raw[k]) s += (1 << ref_exp(k));
      return (s > 4095) ? 4095 : s;
   endfunction

   // Behavioural pipeline: gain-two stages, unity-gain stages 2/6/10, comparator.
   function automatic logic [NR-1:0] model(input longint x, input bit off);
      longint r;
      longint th;
      logic [NR-1:0] b;
      r = x;
      b = '0;
      for (int k = 0; k < NR; k++) begin
         if (k == NR - 1) begin
            b[k] = (r >= HALF);
         end else if (k == 2 || k == 6 || k == 10) begin
            b[k] = (r >= HALF);
            if (b[k]) r = r - HALF;
         end else begin
            th = HALF + ((off && (k == 1 || k == 5 || k == 9)) ? ONE / 64 : 0);
            b[k] = (r >= th);
            r = 2 * r - (b[k] ? ONE : 0);
         end
      end
      return b;
   endfunction

   function automatic int ideal_code(input longint x);
      longint c;
      c = x >>> 8;
      return (c > 4095) ? 4095 : int'(c);
   endfunction

   // Places a sample so that bit k appears floor(k/2) cycles after its strobe (R5).
   task automatic launch(input int base, input logic [NR-1:0] raw, input int expv, input string tag);
      svld[base % 32] = 1'b1;
      for (int k = 0; k < NR; k++)
         if (raw[k]) sbits[(base + k / 2) % 32][k] = 1'b1;
      expq.push_back('{base + 9, expv, tag});
   endtask

   task automatic drain();
      while (expq.size() > 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   // Driver and result monitor, all at the falling edge.
   initial begin
      for (int i = 0; i < 32; i++) begin
         sbits[i] = '0;
         svld[i]  = 1'b0;
      end
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (expq.size() > 0 && expq[0].due == cyc) begin
               chk(code_vld === 1'b1, expq[0].tag, "strobe at latency 8 (R6)", code_vld, 1);
               chk(code === OW'(expq[0].val), expq[0].tag, "code", code, expq[0].val);
               last_code = expq[0].val;
               void'(expq.pop_front());
            end else if (code_vld === 1'b1) begin
               chk(1'b0, "R6", "unexpected result strobe", 1, 0);
            end
         end
         raw_bits = sbits[cyc % 32];
         raw_vld  = svld[cyc % 32];
         sbits[cyc % 32] = '0;
         svld[cyc % 32]  = 1'b0;
         cyc++;
      end
   end

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk(code_vld === 1'b0, "R9", "strobe in reset", code_vld, 0);
      chk(code === '0, "R9", "code in reset", code, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(code_vld === 1'b0, "R9", "strobe after release", code_vld, 0);
      chk(code === '0, "R9", "code after release", code, 0);
   endtask

   task automatic t_single_weights();
      int b;
      b = cyc + 2;
      for (int k = 0; k < NR; k++) launch(b + k, NR'(1) << k, 1 << ref_exp(k), "R1");
      drain();
   endtask

   task automatic t_overlap();
      int b;
      b = cyc + 2;
      launch(b,     15'h000C, 1024, "R2");
      launch(b + 1, 15'h00C0, 128,  "R2");
      launch(b + 2, 15'h0C00, 16,   "R2");
      launch(b + 3, 15'h0CCC, 1168, "R2");
      drain();
   endtask

   task automatic t_ripple();
      int b;
      logic [NR-1:0] p;
      b = cyc + 2;
      p = 15'h7BBA | 15'h0400;
      launch(b, p, ref_code(p), "R3");
      launch(b + 1, 15'h7800, 15, "R3");
      launch(b + 2, 15'h7C00, 23, "R3");
      p = 15'h0BBB;
      launch(b + 3, p, ref_code(p), "R3");
      drain();
   endtask

   task automatic t_overflow();
      int b;
      b = cyc + 2;
      launch(b,     15'h7FFF, 4095, "R4");
      launch(b + 1, 15'h000F, 4095, "R4");
      launch(b + 2, 15'h000B, 3584, "R4");
      launch(b + 3, model(ONE, 1'b0), 4095, "R4");
      drain();
   endtask

   task automatic t_transitions();
      longint xs [12];
      int b;
      xs[0] = HALF - 128;  xs[1] = HALF;      xs[2] = HALF + 256;
      xs[3] = ONE/4 - 256; xs[4] = ONE/4 + 128; xs[5] = ONE/8 - 128;
      xs[6] = ONE/8;       xs[7] = 3*ONE/4 - 300; xs[8] = 3*ONE/4 + 256;
      xs[9] = 0;           xs[10] = ONE - 1;  xs[11] = 7*ONE/8 + 777;
      b = cyc + 2;
      for (int i = 0; i < 12; i++) launch(b + i, model(xs[i], 1'b0), ideal_code(xs[i]), "R10");
      drain();
   endtask

   task automatic t_offset();
      longint xs [6];
      int b;
      xs[0] = 3*ONE/4 + 128;
      xs[1] = 5*ONE/16 + ONE/32 + 128;
      xs[2] = 3*ONE/16 + ONE/256 + 64;
      xs[3] = HALF + 128;
      xs[4] = ONE/4 + ONE/32 + 500;
      xs[5] = ONE - 200;
      b = cyc + 2;
      for (int i = 0; i < 6; i++) launch(b + i, model(xs[i], 1'b1), ideal_code(xs[i]), "R10");
      drain();
   endtask

   task automatic t_back_to_back();
      int b;
      logic [NR-1:0] p;
      b = cyc + 2;
      for (int i = 0; i < 14; i++) begin
         p = (i % 2 == 0) ? (NR'(1) << i) : ~(NR'(1) << i);
         launch(b + i, p, ref_code(p), (i % 2 == 0) ? "R5" : "R7");
      end
      drain();
   endtask

   task automatic t_hold();
      int b;
      b = cyc + 2;
      launch(b, model(ONE/3, 1'b0), ideal_code(ONE/3), "R8");
      drain();
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(code_vld === 1'b0, "R8", "strobe while idle", code_vld, 0);
         chk(code === OW'(last_code), "R8", "code held while idle", code, last_code);
      end
   endtask

   initial begin
      t_reset();
      t_single_weights();
      t_overlap();
      t_ripple();
      t_overflow();
      t_transitions();
      t_offset();
      t_back_to_back();
      t_hold();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule